// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a three-wire stereo serial audio stream (word select, bit clock, data) and turns each frame into one left and one right sample, each 24 bits wide. A one-cycle strobe marks every new pair. All of its logic runs on the master clock. The three serial inputs are brought in through a two-stage synchronizer, and the block detects their edges in the master clock domain.

The block decides on its own where the bit clock comes from. When the bit clock input toggles steadily, the block takes data on its rising edges. When that input is silent, the block makes its own bit tick by dividing the master clock. The divide ratio follows the selected master-clock-to-frame ratio. A format code picks the framing: left-justified 24-bit, or right-justified 24, 20, 18 or 16 bits. Shorter words are sign-extended. A frame that carries fewer bit clocks than its format needs is dropped, and a sticky error flag is raised.

Top module: `aud_serial_rx`

## Requirements
- R1: Format codes 0, 5, 6 and 7 select left-justified 24-bit framing. The first 24 bits after a word-select edge form the word, MSB first, and any later bits in that phase are ignored.
- R2: Format codes 1, 2, 3 and 4 select right-justified words of 24, 20, 18 and 16 bits. The word is made of the last n bits before the next word-select edge, MSB first. Earlier bits in the phase are ignored.
- R3: A right-justified word shorter than 24 bits is sign-extended to 24 bits on both outputs.
- R4: The left phase is word select high and the right phase is word select low. After a left phase and then a right phase, `valid_o` pulses for exactly one cycle. That pulse comes in the cycle after the word-select rising edge that closes the right phase. `left_o` and `right_o` change only with that pulse.
- R5: With no external bit clock, a bit is taken every D master cycles, with the divider restarted at each word-select edge. The ratio code sets D: 0 (128x) gives 2, 1 (192x) gives 4, 2 (256x) gives 4, 3 (384x) gives 8, 4 (512x) gives 8, and 5 to 7 give 4. The 128x, 256x and 512x codes therefore give 64 bits per frame, and the 192x and 384x codes give 48.
- R6: The 16th bit-clock rising edge inside one word-select phase switches the block to external clocking. From then on, data bits are taken on bit-clock rising edges, and the frame in progress is discarded.
- R7: External clocking ends at a word-select rising edge that closes the second consecutive frame period with no bit-clock rising edge. The frame in progress is discarded. A phase with no bit ticks at all is dropped without an error.
- R8: Each phase needs at least 24 bit ticks in left-justified framing and at least n in right-justified n-bit framing, which is 2n per frame. Exactly that many is accepted. A shorter phase sets `short_err_o`, which stays high until reset, and the frame is not delivered.
- R9: After reset the outputs are zero, the block uses internal clocking, and the first word-select edge opens the first usable phase.
- R10: The format and ratio codes are sampled at each word-select rising edge and hold for the whole frame that edge opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_sel | input | 3 | Master-clock-to-frame ratio code (R5) |
| fmt_sel | input | 3 | Framing code (R1, R2) |
| lrck_i | input | 1 | Word select, high for the left channel |
| sclk_i | input | 1 | External bit clock, may be absent |
| sdata_i | input | 1 | Serial data |
| left_o | output | 24 | Last delivered left sample |
| right_o | output | 24 | Last delivered right sample |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| short_err_o | output | 1 | Sticky short-frame flag |
| ext_clk_o | output | 1 | High while the external bit clock is in use |

## Verification
Each phase is padded with ones outside the word, so a design that slices the wrong bits gives a visibly wrong sample. Left-justified frames then show whether bits after the 24th are ignored, and right-justified frames show whether the leading padding is ignored. Words with the sign bit set and clear are sent at 20, 18 and 16 bits to separate correct sign extension from zero fill. Internal-clock frames are sent at three different divide ratios, so a wrong divider shifts every bit.

External-clock runs cover several cases: the frame that performs the switch and must be dropped, phases with exactly the minimum bit count and with one fewer, and a silent stretch of two frame periods that must fall back to internal clocking without raising an error.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int WORD_W = 24;
  localparam int BCNT_W = 7;
  localparam int DIV_W  = 4;
  localparam int LEN_W  = 5;

  // Length of the word carried by a format code.
  function automatic logic [LEN_W-1:0] fmt_len(input logic [2:0] f);
    case (f)
      3'd1:    return LEN_W'(24);
      3'd2:    return LEN_W'(20);
      3'd3:    return LEN_W'(18);
      3'd4:    return LEN_W'(16);
      default: return LEN_W'(24);
    endcase
  endfunction

  // Left-justified framing is every code outside 1..4.
  function automatic logic fmt_is_lj(input logic [2:0] f);
    return !((f >= 3'd1) && (f <= 3'd4));
  endfunction

  // Keep the low n bits and copy bit n-1 upward.
  function automatic logic [WORD_W-1:0] sext_word(input logic [WORD_W-1:0] sr,
                                                 input logic [LEN_W-1:0] n);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < WORD_W; i++) begin
      w[i] = (LEN_W'(i) < n) ? sr[i] : sr[n - LEN_W'(1)];
    end
    return w;
  endfunction

  // Master cycles per internal bit tick, by ratio code.
  function automatic logic [DIV_W-1:0] int_div(input logic [2:0] r);
    case (r)
      3'd0:    return DIV_W'(2);
      3'd1:    return DIV_W'(4);
      3'd2:    return DIV_W'(4);
      3'd3:    return DIV_W'(8);
      3'd4:    return DIV_W'(8);
      default: return DIV_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/aud_rx_clkmode.sv
module aud_rx_clkmode
  import aud_rx_pkg::*;
#(
  parameter int ENTRY_EDGES  = 16,
  parameter int IDLE_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrck_edge,
  input  logic       lrck_rise,
  input  logic       sclk_rise,
  input  logic [2:0] ratio_sel,
  output logic       bit_tick,
  output logic       ext_mode,
  output logic       mode_flip
);

  localparam int EW = $clog2(ENTRY_EDGES + 1);
  localparam int IW = $clog2(IDLE_PERIODS + 1);

  logic [2:0]       ratio_act;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_val;
  logic [EW-1:0]    edge_cnt;
  logic [IW-1:0]    idle_cnt;
  logic             seen_edge;
  logic             int_tick;
  logic             enter_ext;
  logic             leave_ext;

  assign div_val   = int_div(ratio_act);
  assign int_tick  = !lrck_edge && (div_cnt == (div_val >> 1));
  assign enter_ext = !ext_mode && sclk_rise && !lrck_edge &&
                     (edge_cnt == EW'(ENTRY_EDGES - 1));
  assign leave_ext = ext_mode && lrck_rise && !seen_edge && !sclk_rise &&
                     (idle_cnt == IW'(IDLE_PERIODS - 1));
  assign mode_flip = enter_ext || leave_ext;
  assign bit_tick  = ext_mode ? sclk_rise : int_tick;

  // Internal divider, restarted by every word-select edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_act <= 3'd2;
      div_cnt   <= '0;
    end else begin
      if (lrck_rise) ratio_act <= ratio_sel;
      if (lrck_edge)                      div_cnt <= DIV_W'(1);
      else if (div_cnt == div_val - 1'b1) div_cnt <= '0;
      else                                div_cnt <= div_cnt + 1'b1;
    end
  end

  // Clock source selection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_mode  <= 1'b0;
      edge_cnt  <= '0;
      idle_cnt  <= '0;
      seen_edge <= 1'b0;
    end else begin
      if (enter_ext)      ext_mode <= 1'b1;
      else if (leave_ext) ext_mode <= 1'b0;

      if (lrck_edge)
        edge_cnt <= sclk_rise ? EW'(1) : '0;
      else if (sclk_rise && (edge_cnt != EW'(ENTRY_EDGES)))
        edge_cnt <= edge_cnt + 1'b1;

      if (lrck_rise) begin
        seen_edge <= sclk_rise;
        if (seen_edge || sclk_rise || leave_ext) idle_cnt <= '0;
        else if (idle_cnt != IW'(IDLE_PERIODS))  idle_cnt <= idle_cnt + 1'b1;
      end else begin
        seen_edge <= seen_edge || sclk_rise;
        if (enter_ext) idle_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
  import aud_rx_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = BCNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         sdata,
  input  logic         lrck_edge,
  input  logic         lrck_rise,
  input  logic         lrck_lvl,
  input  logic [2:0]   fmt_sel,
  input  logic         disarm,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o,
  output logic         short_err_o,
  output logic [2:0]   word_fmt_o
);

  logic [2:0]       fmt_act;
  logic [W-1:0]     shreg;
  logic [CW-1:0]    bcnt;
  logic             armed;
  logic             left_ok;
  logic [W-1:0]     left_hold;
  logic             is_lj;
  logic [LEN_W-1:0] need;
  logic             live;
  logic             short_ph;
  logic             good_ph;
  logic             capture;
  logic [W-1:0]     word;
  logic             ending_left;

  assign is_lj       = fmt_is_lj(fmt_act);
  assign need        = fmt_len(fmt_act);
  assign live        = armed && (bcnt != '0);
  assign short_ph    = live && (bcnt < CW'(need));
  assign good_ph     = live && !short_ph;
  assign capture     = bit_tick && (!is_lj || (bcnt < CW'(W)));
  assign word        = is_lj ? shreg : sext_word(shreg, need);
  assign ending_left = !lrck_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_act     <= 3'd0;
      shreg       <= '0;
      bcnt        <= '0;
      armed       <= 1'b0;
      left_ok     <= 1'b0;
      left_hold   <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      short_err_o <= 1'b0;
      word_fmt_o  <= 3'd0;
    end else begin
      valid_o <= 1'b0;
      if (lrck_rise) fmt_act <= fmt_sel;

      if (lrck_edge) begin
        bcnt <= bit_tick ? CW'(1) : '0;
        if (bit_tick) shreg <= {shreg[W-2:0], sdata};
        if (ending_left) begin
          left_ok   <= good_ph;
          left_hold <= word;
        end else begin
          if (good_ph && left_ok) begin
            left_o     <= left_hold;
            right_o    <= word;
            valid_o    <= 1'b1;
            word_fmt_o <= fmt_act;
          end
          left_ok <= 1'b0;
        end
        if (short_ph) short_err_o <= 1'b1;
      end else begin
        if (bit_tick && (bcnt != '1)) bcnt <= bcnt + 1'b1;
        if (capture) shreg <= {shreg[W-2:0], sdata};
      end

      if (disarm) begin
        armed   <= 1'b0;
        left_ok <= 1'b0;
      end else if (lrck_edge) begin
        armed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_EDGES  = 16,
  parameter int IDLE_PERIODS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ratio_sel,
  input  logic [2:0]        fmt_sel,
  input  logic              lrck_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              short_err_o,
  output logic              ext_clk_o
);

  logic [2:0] pins_s;
  logic       lrck_s, sclk_s, sdata_s;
  logic       lrck_p, sclk_p;
  logic       lrck_edge, lrck_rise, sclk_rise;
  logic       bit_tick, mode_flip;
  logic [2:0] word_fmt;

  aud_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({lrck_i, sclk_i, sdata_i}),
    .q_o   (pins_s)
  );

  assign {lrck_s, sclk_s, sdata_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_p <= 1'b0;
      sclk_p <= 1'b0;
    end else begin
      lrck_p <= lrck_s;
      sclk_p <= sclk_s;
    end
  end

  assign lrck_edge = lrck_s ^ lrck_p;
  assign lrck_rise = lrck_s & ~lrck_p;
  assign sclk_rise = sclk_s & ~sclk_p;

  aud_rx_clkmode #(.ENTRY_EDGES(ENTRY_EDGES), .IDLE_PERIODS(IDLE_PERIODS)) u_clkmode (
    .clk       (clk),
    .rst_n     (rst_n),
    .lrck_edge (lrck_edge),
    .lrck_rise (lrck_rise),
    .sclk_rise (sclk_rise),
    .ratio_sel (ratio_sel),
    .bit_tick  (bit_tick),
    .ext_mode  (ext_clk_o),
    .mode_flip (mode_flip)
  );

  aud_rx_framer #(.W(WORD_W), .CW(BCNT_W)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .sdata       (sdata_s),
    .lrck_edge   (lrck_edge),
    .lrck_rise   (lrck_rise),
    .lrck_lvl    (lrck_s),
    .fmt_sel     (fmt_sel),
    .disarm      (mode_flip),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o),
    .short_err_o (short_err_o),
    .word_fmt_o  (word_fmt)
  );

endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_o,
  input logic [23:0] left_o,
  input logic [23:0] right_o,
  input logic        short_err_o,
  input logic        ext_clk_o,
  input logic        lrck_rise,
  input logic        sclk_rise,
  input logic [2:0]  word_fmt
);

  function automatic int width_of(input logic [2:0] f);
    case (f)
      3'd2:    return 20;
      3'd3:    return 18;
      3'd4:    return 16;
      default: return 24;
    endcase
  endfunction

  // True when every bit above the word is a copy of its top bit.
  function automatic logic top_bits_agree(input logic [23:0] x, input logic [2:0] f);
    int n;
    logic ok;
    n  = width_of(f);
    ok = 1'b1;
    for (int i = 0; i < 24; i++) begin
      if (i >= n && x[i] != x[n-1]) ok = 1'b0;
    end
    return ok;
  endfunction

  p_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (top_bits_agree(left_o, word_fmt) && top_bits_agree(right_o, word_fmt)));

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_strobe_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(lrck_rise));

  p_hold_outputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  p_enter_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_clk_o) |-> $past(sclk_rise));

  p_leave_on_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_clk_o) |-> $past(lrck_rise));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    short_err_o |=> short_err_o);

  p_err_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_err_o) |-> !valid_o);

endmodule

bind aud_serial_rx aud_serial_rx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_o     (valid_o),
  .left_o      (left_o),
  .right_o     (right_o),
  .short_err_o (short_err_o),
  .ext_clk_o   (ext_clk_o),
  .lrck_rise   (lrck_rise),
  .sclk_rise   (sclk_rise),
  .word_fmt    (word_fmt)
);

// File: tb/aud_serial_rx_bench.sv
module aud_serial_rx_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ratio_sel = 3'd2;
  logic [2:0]  fmt_sel = 3'd0;
  logic        lrck = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o, short_err_o, ext_clk_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_serial_rx u_aud_serial_rx (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .fmt_sel(fmt_sel),
    .lrck_i(lrck), .sclk_i(sclk), .sdata_i(sdata),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .short_err_o(short_err_o), .ext_clk_o(ext_clk_o)
  );

  typedef struct { logic [23:0] l; logic [23:0] r; string tag; } exp_t;
  exp_t sb[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] f);
    if (f == 3'd1) return 24;
    if (f == 3'd2) return 20;
    if (f == 3'd3) return 18;
    if (f == 3'd4) return 16;
    return 24;
  endfunction

  function automatic bit lj(input logic [2:0] f);
    return (f == 3'd0) || (f >= 3'd5);
  endfunction

  function automatic logic [23:0] expect_word(input logic [23:0] w, input logic [2:0] f);
    int n;
    logic signed [23:0] t;
    if (lj(f)) return w;
    n = len_of(f);
    t = w << (24 - n);
    return t >>> (24 - n);
  endfunction

  // Serial bit k of a phase of nb bits; padding is all ones.
  function automatic logic phase_bit(input logic [23:0] w, input logic [2:0] f,
                                     input int k, input int nb);
    int n;
    if (lj(f)) return (k < 24) ? w[23-k] : 1'b1;
    n = len_of(f);
    if (k >= nb - n) return w[n-1-(k-(nb-n))];
    return 1'b1;
  endfunction

  function automatic int div_of(input logic [2:0] r);
    if (r == 3'd0) return 2;
    if (r == 3'd3 || r == 3'd4) return 8;
    return 4;
  endfunction

  task automatic drive_phase(input logic lvl, input logic [23:0] w, input int nb, input bit ext);
    for (int k = 0; k < nb; k++) begin
      if (k == 0) lrck = lvl;
      sdata = phase_bit(w, fmt_sel, k, nb);
      if (ext) begin
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
      end else begin
        repeat (div_of(ratio_sel)) @(negedge clk);
      end
    end
    sclk = 1'b0;
  endtask

  task automatic frame(input logic [23:0] l, input logic [23:0] r, input int nl, input int nr,
                       input bit ext, input bit want, input string tag);
    exp_t e;
    if (want) begin
      e.l = expect_word(l, fmt_sel);
      e.r = expect_word(r, fmt_sel);
      e.tag = tag;
      sb.push_back(e);
    end
    drive_phase(1'b1, l, nl, ext);
    drive_phase(1'b0, r, nr, ext);
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (valid_o && rst_n) begin
        if (sb.size() == 0) begin
          check(1'b0, "R4", "unexpected sample", {left_o, right_o}, 48'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check((left_o == e.l) && (right_o == e.r), e.tag, "sample",
                {left_o, right_o}, {e.l, e.r});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(valid_o == 1'b0 && short_err_o == 1'b0, "R9", "strobe/error after reset",
          {46'h0, valid_o, short_err_o}, 48'h0);
    check(ext_clk_o == 1'b0, "R9", "clock mode after reset", {47'h0, ext_clk_o}, 48'h0);
    check(left_o == 24'h0 && right_o == 24'h0, "R9", "samples after reset",
          {left_o, right_o}, 48'h0);

    // Internal clock, 256x ratio, left-justified aliases (R1, R10)
    fmt_sel = 3'd0; frame(24'hA5C3F1, 24'h3C0F96, 32, 32, 0, 1, "R1");
    fmt_sel = 3'd5; frame(24'h123456, 24'hFEDCBA, 32, 32, 0, 1, "R1/R10");
    fmt_sel = 3'd7; frame(24'h800001, 24'h7FFFFE, 32, 32, 0, 1, "R1");
    // Right-justified lengths (R2, R3)
    fmt_sel = 3'd1; frame(24'h00F00D, 24'hC0FFEE, 32, 32, 0, 1, "R2");
    fmt_sel = 3'd2; frame(24'h081234, 24'h03ABCD, 32, 32, 0, 1, "R3");
    fmt_sel = 3'd3; frame(24'h020F0F, 24'h01F0F0, 32, 32, 0, 1, "R3");
    fmt_sel = 3'd4; frame(24'h008001, 24'h007FFE, 32, 32, 0, 1, "R3");
    // Other divide ratios (R5)
    ratio_sel = 3'd3; fmt_sel = 3'd1; frame(24'h5A5A5A, 24'hA5A5A5, 24, 24, 0, 1, "R5");
    ratio_sel = 3'd0; fmt_sel = 3'd4; frame(24'h00ABCD, 24'h001234, 32, 32, 0, 1, "R5");
    ratio_sel = 3'd2; fmt_sel = 3'd0; frame(24'h0F1E2D, 24'hF0E1D2, 32, 32, 0, 1, "R5");
    check(short_err_o == 1'b0, "R8", "no error on full frames", {47'h0, short_err_o}, 48'h0);

    // Switch to the external bit clock (R6)
    frame(24'h111111, 24'h222222, 32, 32, 1, 0, "R6");
    check(ext_clk_o == 1'b1, "R6", "external mode entered", {47'h0, ext_clk_o}, 48'h1);
    frame(24'h333333, 24'h444444, 32, 32, 1, 1, "R6");
    frame(24'h9ABCDE, 24'h654321, 32, 32, 1, 1, "R6");

    // Minimum bit counts (R8)
    fmt_sel = 3'd2; frame(24'h0FFFFF, 24'h080000, 20, 20, 1, 1, "R8");
    frame(24'h012345, 24'h054321, 20, 19, 1, 0, "R8");
    fmt_sel = 3'd0; frame(24'hABCDEF, 24'h135790, 24, 24, 1, 1, "R8");
    check(short_err_o == 1'b1, "R8", "error after short phase", {47'h0, short_err_o}, 48'h1);
    frame(24'h777777, 24'h888888, 23, 32, 1, 0, "R8");
    frame(24'h246801, 24'h975310, 32, 32, 1, 1, "R8");

    // Bit clock stops: back to internal (R7)
    frame(24'h000000, 24'h000000, 32, 32, 0, 0, "R7");
    frame(24'h000000, 24'h000000, 32, 32, 0, 0, "R7");
    check(ext_clk_o == 1'b1, "R7", "still external before second silent period ends",
          {47'h0, ext_clk_o}, 48'h1);
    frame(24'h000000, 24'h000000, 32, 32, 0, 0, "R7");
    check(ext_clk_o == 1'b0, "R7", "internal mode restored", {47'h0, ext_clk_o}, 48'h0);
    frame(24'hC3C3C3, 24'h3C3C3C, 32, 32, 0, 1, "R7");

    @(negedge clk); lrck = 1'b1;
    repeat (40) @(negedge clk);
    check(short_err_o == 1'b1, "R8", "error flag still held", {47'h0, short_err_o}, 48'h1);
    check(sb.size() == 0, "R4", "all expected samples delivered", 48'(sb.size()), 48'h0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule